// File: doc/BRIEF.md
# Byte ALU with Status Register

This block is the arithmetic and logic stage of a small 8-bit processor datapath. It takes two data operands, one of them possibly an immediate, and a five-bit operation code. It gives a result at once, through combinational logic, and keeps an eight-bit status register. For each operation, the register updates only the flags that the operation defines and holds every other flag.

Carry-in for the carry-using operations comes from the C bit already in the status register. A chain of bytes can therefore be added, subtracted or rotated by issuing one operation per byte. The status register changes only on a clock edge while `exec_en` is high.

The status layout is fixed, from bit 7 down to bit 0:

| Bit | Flag | Meaning |
|-----|------|---------|
| 7 | I | interrupt enable |
| 6 | T | bit store |
| 5 | H | half carry |
| 4 | S | sign |
| 3 | V | overflow |
| 2 | N | negative |
| 1 | Z | zero |
| 0 | C | carry |

Top module: `byte_alu_sreg`

## Requirements
- R1: After reset, `status` reads 0x00. The flag positions are I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0.
- R2: ADD (op 0) gives opa+opb, and ADC (op 1) gives opa+opb+C. Both write C (carry out of bit 7), H (carry out of bit 3), V (two's-complement overflow), N (result bit 7), Z (result is zero) and S. I and T are kept.
- R3: SUB (op 2) gives opa-opb, and SBC (op 3) gives opa-opb-C. C is the borrow out of bit 7, H is the borrow out of bit 3, and V is signed overflow. N, Z and S are also written.
- R4: For SBC (op 3), the new Z is 1 only when the result is zero and Z was already 1. A zero result never sets a cleared Z.
- R5: AND (op 4), OR (op 5) and XOR (op 6) clear V and write N, Z and S=N. C, H, I and T are kept.
- R6: INC (op 9) gives opa+1 and sets V only when opa is 0x7F. DEC (op 10) gives opa-1 and sets V only when opa is 0x80. Both write N, Z and S, and keep C and H.
- R7: COM (op 7) gives 0xFF-opa, sets C, clears V and keeps H. NEG (op 8) gives 0x00-opa, sets C when opa is nonzero, sets V when opa is 0x80 and sets H on a borrow out of bit 3.
- R8: LSL (op 11) shifts left and fills bit 0 with 0. LSR (op 12) shifts right and fills bit 7 with 0. ROL (op 13) moves the old C into bit 0. ROR (op 14) moves the old C into bit 7. ASR (op 15) shifts right and keeps bit 7. In all five, the new C is the bit shifted out, V=N^C, N, Z and S are written, and H is kept.
- R9: SWAP (op 16) exchanges the upper and lower nibbles of opa and changes no flag. Codes 19 to 31 output opa and change no flag.
- R10: BSET (op 17) writes 1 into the status bit numbered by `flag_sel`, and BCLR (op 18) writes 0 there. No other status bit changes, and `result` equals opa.
- R11: After every operation with code 0 to 15, S equals N XOR V.
- R12: With `exec_en` low, `status` holds its value whatever the other inputs do. `result` still follows the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| exec_en | input | 1 | commit the flag update at the next edge |
| op | input | 5 | operation code |
| opa | input | DATA_W | first operand, or the only operand |
| opb | input | DATA_W | second operand (register or immediate) |
| flag_sel | input | 3 | status bit index for BSET/BCLR |
| result | output | DATA_W | combinational result |
| status | output | 8 | status register |

## Verification
A wrong flag in this block shows up at `status` one clock after the operation that produced it. A wrong C can also show up earlier: it appears on `result` in the same cycle as the next carry-using or rotate operation. The Z chain behaviour can only be seen across two operations in a row, so it is tested by a directed subtract-then-subtract-with-carry sequence whose result is zero. A status register that wrongly updates while `exec_en` is low would show a changed flag after a cycle in which the block was not meant to act, and a dedicated idle check looks for exactly that.

// File: rtl/alu_sreg_pkg.sv
`timescale 1ns/1ps
package alu_sreg_pkg;
   localparam int FLAG_W = 8;
   localparam int SEL_W  = $clog2(FLAG_W);
   localparam int FL_C = 0;
   localparam int FL_Z = 1;
   localparam int FL_N = 2;
   localparam int FL_V = 3;
   localparam int FL_S = 4;
   localparam int FL_H = 5;

   typedef enum logic [4:0] {
      OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
      OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_COM  = 5'd7,
      OP_NEG  = 5'd8,  OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_LSL  = 5'd11,
      OP_LSR  = 5'd12, OP_ROL  = 5'd13, OP_ROR  = 5'd14, OP_ASR  = 5'd15,
      OP_SWAP = 5'd16, OP_BSET = 5'd17, OP_BCLR = 5'd18
   } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
   parameter int W  = 8,
   parameter int HW = W / 2
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         ci,
   input  logic         sub,
   output logic [W-1:0] r,
   output logic         co,
   output logic         ho,
   output logic         vo
);
   logic [W:0]  full;
   logic [HW:0] low;

   always_comb begin
      if (sub) begin
         full = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, ci};
         low  = {1'b0, x[HW-1:0]} - {1'b0, y[HW-1:0]} - {{HW{1'b0}}, ci};
      end else begin
         full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
         low  = {1'b0, x[HW-1:0]} + {1'b0, y[HW-1:0]} + {{HW{1'b0}}, ci};
      end
      r  = full[W-1:0];
      co = full[W];
      ho = low[HW];
      if (sub)
         vo = (x[W-1] ^ y[W-1]) & (full[W-1] ^ x[W-1]);
      else
         vo = ~(x[W-1] ^ y[W-1]) & (full[W-1] ^ x[W-1]);
   end
endmodule

// File: rtl/alu_logic_shift.sv
`timescale 1ns/1ps
module alu_logic_shift
   import alu_sreg_pkg::*;
#(
   parameter int W  = 8,
   parameter int HW = W / 2
) (
   input  alu_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] r,
   output logic         co
);
   always_comb begin
      r  = a;
      co = cin;
      case (op)
         OP_AND:  r = a & b;
         OP_OR:   r = a | b;
         OP_XOR:  r = a ^ b;
         OP_LSL:  begin r = {a[W-2:0], 1'b0};   co = a[W-1]; end
         OP_LSR:  begin r = {1'b0, a[W-1:1]};   co = a[0];   end
         OP_ROL:  begin r = {a[W-2:0], cin};    co = a[W-1]; end
         OP_ROR:  begin r = {cin, a[W-1:1]};    co = a[0];   end
         OP_ASR:  begin r = {a[W-1], a[W-1:1]}; co = a[0];   end
         OP_SWAP: r = {a[HW-1:0], a[W-1:HW]};
         default: r = a;
      endcase
   end
endmodule

// File: rtl/alu_flag_next.sv
`timescale 1ns/1ps
module alu_flag_next
   import alu_sreg_pkg::*;
#(
   parameter int W           = 8,
   parameter bit SBC_Z_CHAIN = 1'b1
) (
   input  alu_op_e           op,
   input  logic [FLAG_W-1:0] cur,
   input  logic [W-1:0]      r,
   input  logic              ar_c,
   input  logic              ar_h,
   input  logic              ar_v,
   input  logic              sh_c,
   input  logic [SEL_W-1:0]  bsel,
   output logic [FLAG_W-1:0] nxt
);
   logic neg_bit, zero, sbc_z;

   assign neg_bit = r[W-1];
   assign zero    = ~|r;

   generate
      if (SBC_Z_CHAIN) begin : g_zchain
         assign sbc_z = zero & cur[FL_Z];
      end else begin : g_zplain
         assign sbc_z = zero;
      end
   endgenerate

   always_comb begin
      nxt = cur;
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
            nxt[FL_H] = ar_h;
            nxt[FL_C] = ar_c;
            nxt[FL_V] = ar_v;
            nxt[FL_N] = neg_bit;
            nxt[FL_Z] = (op == OP_SBC) ? sbc_z : zero;
            nxt[FL_S] = neg_bit ^ ar_v;
         end
         OP_AND, OP_OR, OP_XOR: begin
            nxt[FL_V] = 1'b0;
            nxt[FL_N] = neg_bit;
            nxt[FL_Z] = zero;
            nxt[FL_S] = neg_bit;
         end
         OP_INC, OP_DEC: begin
            nxt[FL_V] = ar_v;
            nxt[FL_N] = neg_bit;
            nxt[FL_Z] = zero;
            nxt[FL_S] = neg_bit ^ ar_v;
         end
         OP_COM: begin
            nxt[FL_C] = 1'b1;
            nxt[FL_V] = 1'b0;
            nxt[FL_N] = neg_bit;
            nxt[FL_Z] = zero;
            nxt[FL_S] = neg_bit;
         end
         OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
            nxt[FL_C] = sh_c;
            nxt[FL_V] = neg_bit ^ sh_c;
            nxt[FL_N] = neg_bit;
            nxt[FL_Z] = zero;
            nxt[FL_S] = sh_c;
         end
         OP_BSET: nxt[bsel] = 1'b1;
         OP_BCLR: nxt[bsel] = 1'b0;
         default: nxt = cur;
      endcase
   end
endmodule

// File: rtl/byte_alu_sreg.sv
`timescale 1ns/1ps
module byte_alu_sreg
   import alu_sreg_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit SBC_Z_CHAIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec_en,
   input  logic [4:0]        op,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [SEL_W-1:0]  flag_sel,
   output logic [DATA_W-1:0] result,
   output logic [FLAG_W-1:0] status
);
   localparam int HALF_W = DATA_W / 2;

   generate
      if (DATA_W < 8 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("byte_alu_sreg: DATA_W must be even and at least 8");
      end
   endgenerate

   alu_op_e           op_e;
   logic [DATA_W-1:0] ax, ay, ar_r, ls_r;
   logic              aci, asub, ar_c, ar_h, ar_v, sh_c, use_arith;
   logic [FLAG_W-1:0] sreg_q, sreg_d;

   assign op_e = alu_op_e'(op);

   always_comb begin
      ax   = opa;
      ay   = opb;
      aci  = 1'b0;
      asub = 1'b0;
      case (op_e)
         OP_ADC: aci = sreg_q[FL_C];
         OP_SUB: asub = 1'b1;
         OP_SBC: begin asub = 1'b1; aci = sreg_q[FL_C]; end
         OP_NEG: begin ax = '0; ay = opa; asub = 1'b1; end
         OP_COM: begin ax = '1; ay = opa; asub = 1'b1; end
         OP_INC: begin ay = '0; aci = 1'b1; end
         OP_DEC: begin ay = '0; aci = 1'b1; asub = 1'b1; end
         default: ;
      endcase
   end

   alu_addsub #(.W(DATA_W), .HW(HALF_W)) u_addsub (
      .x(ax), .y(ay), .ci(aci), .sub(asub),
      .r(ar_r), .co(ar_c), .ho(ar_h), .vo(ar_v)
   );

   alu_logic_shift #(.W(DATA_W), .HW(HALF_W)) u_logic (
      .op(op_e), .a(opa), .b(opb), .cin(sreg_q[FL_C]),
      .r(ls_r), .co(sh_c)
   );

   assign use_arith = op_e inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC,
                                   OP_COM, OP_NEG, OP_INC, OP_DEC};
   assign result = use_arith ? ar_r : ls_r;

   alu_flag_next #(.W(DATA_W), .SBC_Z_CHAIN(SBC_Z_CHAIN)) u_flags (
      .op(op_e), .cur(sreg_q), .r(result),
      .ar_c(ar_c), .ar_h(ar_h), .ar_v(ar_v), .sh_c(sh_c),
      .bsel(flag_sel), .nxt(sreg_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sreg_q <= '0;
      else if (exec_en) sreg_q <= sreg_d;
   end

   assign status = sreg_q;
endmodule

// File: rtl/byte_alu_sreg_chk.sv
`timescale 1ns/1ps
module byte_alu_sreg_chk
   import alu_sreg_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit SBC_Z_CHAIN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exec_en,
   input logic [4:0]        op,
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] opb,
   input logic [SEL_W-1:0]  flag_sel,
   input logic [DATA_W-1:0] result,
   input logic [FLAG_W-1:0] status
);
   localparam int HW = DATA_W / 2;

   p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_en |=> $stable(status));

   p_sign_link_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && op < 5'd16) |=> status[FL_S] == (status[FL_N] ^ status[FL_V]));

   p_swap_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && op == 5'd16) |=> $stable(status));

   p_swap_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 5'd16) |-> result == {opa[HW-1:0], opa[DATA_W-1:HW]});

   p_logic_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && op inside {5'd4, 5'd5, 5'd6}) |=>
         (status[FL_C] == $past(status[FL_C])) && !status[FL_V]);

   p_incdec_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && op inside {5'd9, 5'd10}) |=>
         $stable(status[FL_C]) && $stable(status[FL_H]));

   p_com_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && op == 5'd7) |=> status[FL_C] && !status[FL_V]);

   p_bit_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && op == 5'd17) |=> status[$past(flag_sel)]);

   generate
      if (SBC_Z_CHAIN) begin : g_zchk
         p_sbc_zchain_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (exec_en && op == 5'd3 && !status[FL_Z]) |=> !status[FL_Z]);
      end
   endgenerate

   logic unused_ok;
   assign unused_ok = ^opb;
endmodule

bind byte_alu_sreg byte_alu_sreg_chk #(.DATA_W(DATA_W), .SBC_Z_CHAIN(SBC_Z_CHAIN)) u_chk (
   .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op(op), .opa(opa), .opb(opb),
   .flag_sel(flag_sel), .result(result), .status(status)
);

// File: tb/byte_alu_sreg_bench.sv
`timescale 1ns/1ps
module byte_alu_sreg_bench;
   import alu_sreg_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       exec_en = 1'b0;
   logic [4:0] op = '0;
   logic [7:0] opa = '0, opb = '0;
   logic [2:0] flag_sel = '0;
   logic [7:0] result, status;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] exp_st = 8'h00;

   always #2.5 clk = ~clk;

   byte_alu_sreg u_byte_alu_sreg (
      .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op(op), .opa(opa), .opb(opb),
      .flag_sel(flag_sel), .result(result), .status(status)
   );

   // {op, flag_sel, opa, opb}
   localparam int NV = 30;
   localparam logic [23:0] VEC [NV] = '{
      {OP_ADD, 3'd0, 8'h3A, 8'h27}, {OP_ADD, 3'd0, 8'h7F, 8'h01},
      {OP_ADD, 3'd0, 8'hFF, 8'h01}, {OP_ADC, 3'd0, 8'h80, 8'h80},
      {OP_ADC, 3'd0, 8'h0F, 8'h00}, {OP_SUB, 3'd0, 8'h50, 8'h70},
      {OP_SBC, 3'd0, 8'h00, 8'h00}, {OP_SUB, 3'd0, 8'h80, 8'h01},
      {OP_SBC, 3'd0, 8'h12, 8'h34}, {OP_AND, 3'd0, 8'hF0, 8'h3C},
      {OP_OR,  3'd0, 8'h00, 8'h00}, {OP_XOR, 3'd0, 8'hAA, 8'h55},
      {OP_COM, 3'd0, 8'h00, 8'h00}, {OP_COM, 3'd0, 8'h5A, 8'h00},
      {OP_NEG, 3'd0, 8'h80, 8'h00}, {OP_NEG, 3'd0, 8'h00, 8'h00},
      {OP_NEG, 3'd0, 8'h01, 8'h00}, {OP_INC, 3'd0, 8'h7F, 8'h00},
      {OP_INC, 3'd0, 8'hFF, 8'h00}, {OP_DEC, 3'd0, 8'h80, 8'h00},
      {OP_DEC, 3'd0, 8'h01, 8'h00}, {OP_LSL, 3'd0, 8'h81, 8'h00},
      {OP_LSR, 3'd0, 8'h01, 8'h00}, {OP_ROL, 3'd0, 8'h40, 8'h00},
      {OP_ROR, 3'd0, 8'h02, 8'h00}, {OP_ASR, 3'd0, 8'h81, 8'h00},
      {OP_SWAP,3'd0, 8'hA5, 8'h00}, {OP_BSET,3'd6, 8'h11, 8'h00},
      {OP_BCLR,3'd0, 8'h22, 8'h00}, {OP_ROR, 3'd0, 8'h00, 8'h00}
   };

   function automatic string req_tag(input int o);
      if (o <= 1)  return "R2 R11";
      if (o <= 3)  return "R3 R11";
      if (o <= 6)  return "R5 R11";
      if (o <= 8)  return "R7 R11";
      if (o <= 10) return "R6 R11";
      if (o <= 15) return "R8 R11";
      if (o == 16) return "R9";
      return "R10";
   endfunction

   // Reference model written from the requirements: returns {result, status}
   function automatic logic [15:0] ref_step(input int o, input logic [7:0] a, b,
                                            input int bs, input logic [7:0] f);
      logic [7:0] r, nf;
      int s, lo, ci;
      logic c, h, v;
      nf = f;
      r  = a;
      ci = int'(f[0]);
      c = 1'b0; h = 1'b0; v = 1'b0;
      case (o)
         0, 1: begin
            s  = int'(a) + int'(b) + ((o == 1) ? ci : 0);
            lo = int'(a & 8'h0F) + int'(b & 8'h0F) + ((o == 1) ? ci : 0);
            r = s[7:0]; c = (s > 255); h = (lo > 15);
            v = (a[7] == b[7]) && (r[7] != a[7]);
         end
         2, 3: begin
            s  = int'(a) - int'(b) - ((o == 3) ? ci : 0);
            lo = int'(a & 8'h0F) - int'(b & 8'h0F) - ((o == 3) ? ci : 0);
            r = s[7:0]; c = (s < 0); h = (lo < 0);
            v = (a[7] != b[7]) && (r[7] != a[7]);
         end
         4: r = a & b;
         5: r = a | b;
         6: r = a ^ b;
         7: begin r = 8'hFF - a; c = 1'b1; end
         8: begin r = 8'h00 - a; c = (a != 0); h = ((a & 8'h0F) != 0); v = (a == 8'h80); end
         9: begin r = a + 8'h01; v = (a == 8'h7F); end
         10: begin r = a - 8'h01; v = (a == 8'h80); end
         11: begin r = a << 1; c = a[7]; end
         12: begin r = a >> 1; c = a[0]; end
         13: begin r = {a[6:0], f[0]}; c = a[7]; end
         14: begin r = {f[0], a[7:1]}; c = a[0]; end
         15: begin r = {a[7], a[7:1]}; c = a[0]; end
         16: r = {a[3:0], a[7:4]};
         17: nf[bs] = 1'b1;
         18: nf[bs] = 1'b0;
         default: ;
      endcase
      if (o >= 11 && o <= 15) v = r[7] ^ c;
      if (o <= 15) begin
         nf[2] = r[7];
         nf[3] = v;
         nf[4] = r[7] ^ v;
         nf[1] = (r == 0);
         if (o == 3) nf[1] = (r == 0) && f[1];
      end
      if (o <= 3 || o == 8) begin nf[0] = c; nf[5] = h; end
      if (o == 7 || (o >= 11 && o <= 15)) nf[0] = c;
      return {r, nf};
   endfunction

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(input int o, input logic [7:0] a, b, input int bs,
                         input string tag);
      logic [15:0] e;
      @(negedge clk);
      op = 5'(o); opa = a; opb = b; flag_sel = 3'(bs); exec_en = 1'b1;
      e = ref_step(o, a, b, bs, exp_st);
      #1 check8({tag, " result"}, result, e[15:8]);
      @(negedge clk);
      exec_en = 1'b0;
      exp_st = e[7:0];
      check8({tag, " status"}, status, exp_st);
   endtask

   task automatic hand_op(input int o, input logic [7:0] a, b, input int bs,
                          input logic [7:0] er, input logic [7:0] ef, input string tag);
      @(negedge clk);
      op = 5'(o); opa = a; opb = b; flag_sel = 3'(bs); exec_en = 1'b1;
      #1 check8({tag, " result"}, result, er);
      @(negedge clk);
      exec_en = 1'b0;
      exp_st = ef;
      check8({tag, " status"}, status, ef);
   endtask

   task automatic report;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #200000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check8("R1 reset status", status, 8'h00);

      // R4: multi-byte compare chain with hand-computed expectations
      hand_op(OP_SUB, 8'h10, 8'h10, 0, 8'h00, 8'h02, "R3 sub zero");
      hand_op(OP_SBC, 8'h05, 8'h05, 0, 8'h00, 8'h02, "R4 sbc keeps Z");
      hand_op(OP_SUB, 8'h00, 8'h01, 0, 8'hFF, 8'h35, "R3 sub borrow");
      hand_op(OP_SBC, 8'h01, 8'h00, 0, 8'h00, 8'h00, "R4 sbc zero no set");

      // R12: idle cycle must not touch status; result still combinational
      @(negedge clk);
      op = OP_ADD; opa = 8'hFF; opb = 8'h01; exec_en = 1'b0;
      #1 check8("R12 idle result", result, 8'h00);
      @(negedge clk);
      check8("R12 idle status", status, exp_st);

      // R10: single-bit writes at the top position
      hand_op(OP_BSET, 8'h3C, 8'h00, 7, 8'h3C, 8'h80, "R10 bset I");
      hand_op(OP_BCLR, 8'h3C, 8'h00, 7, 8'h3C, 8'h00, "R10 bclr I");

      for (int i = 0; i < NV; i++) begin
         logic [23:0] v;
         v = VEC[i];
         run_op(int'(v[23:19]), v[15:8], v[7:0], int'(v[18:16]), req_tag(int'(v[23:19])));
      end

      // R9: unused code passes opa and keeps flags
      run_op(25, 8'h6B, 8'h00, 0, "R9 unused code");

      report();
      $finish;
   end
endmodule